// File: doc/BRIEF.md
# Transmit Frame Replay Buffer

This block sits between the engine that fetches transmit data from system memory and the Ethernet transmitter. Bytes arrive on the write side, each with a flag that marks the final byte of a frame. The block keeps several frames at once and streams them to the transmitter in the order they were written. A valid/ready handshake carries every byte to the transmitter, and an end flag comes with the last byte of each frame.

Two read pointers govern the storage. The speculative read pointer walks through the frame being sent. The committed pointer marks the oldest byte whose space is still reserved. In the default mode a frame must be complete before the transmitter may see it. Its space stays reserved until the transmitter confirms the frame went out. If a collision is signalled first, the speculative pointer jumps back to the frame start and the frame is sent again without fetching it over the bus a second time.

A low-latency mode is also selected by an input. In that mode, bytes may stream out before the end flag is written, and each byte's space is freed as soon as it is read. A collision in that mode after some bytes have gone out cannot be replayed. The block then raises a restart request to the fetch engine and discards what is left of the abandoned frame.

Top module: `tx_replay_buf`

## Requirements
- R1: A byte is stored when wrValid is high and wrFull is low. wrFull is high when 2^ADDR_W bytes are held whose space is still reserved. A byte offered while wrFull is high is dropped.
- R2: With cutThrough low, rdValid is high only while at least one complete frame (a stored byte with the end flag) is held. rdFrameAvail is high exactly when at least one complete frame is held that has not yet been released or discarded.
- R3: Bytes leave in write order on rdData, and rdLast is high on a frame's final byte. After that final byte is accepted (rdValid and rdReady both high), rdValid stays low until frameDone or retryReq is pulsed.
- R4: With cutThrough low, a retryReq pulse moves reading back to the first byte of the frame being sent, and the same bytes are then sent again. This holds whether or not any bytes have already been read.
- R5: A frameDone pulse after a frame's final byte has been accepted releases that frame. Its space is freed, and streaming of the next frame begins. A frameDone pulse at any other time has no effect.
- R6: With cutThrough low, reading bytes frees no space. wrFull stays high until a frame is released.
- R7: With cutThrough high, rdValid is high whenever an unread byte is held, and each byte accepted by the transmitter frees its space at once.
- R8: With cutThrough high, a retryReq after at least one byte of the current frame was read makes restartReq high for exactly one cycle. The stored bytes of that frame, up to and including its end-flagged byte, are discarded and never shown on rdValid. A retryReq before any byte of the frame was read has no effect.
- R9: After reset, no data is held: rdValid, rdFrameAvail, wrFull and restartReq are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cutThrough | input | 1 | High selects low-latency streaming mode |
| wrValid | input | 1 | Write byte offered |
| wrData | input | DATA_W | Write byte |
| wrLast | input | 1 | Offered byte ends its frame |
| wrFull | output | 1 | No free entry |
| rdValid | output | 1 | Byte offered to transmitter |
| rdData | output | DATA_W | Byte to transmitter |
| rdLast | output | 1 | Offered byte ends its frame |
| rdReady | input | 1 | Transmitter accepts the byte |
| rdFrameAvail | output | 1 | At least one complete frame held |
| retryReq | input | 1 | Collision: send current frame again |
| frameDone | input | 1 | Current frame confirmed sent |
| restartReq | output | 1 | Frame cannot be replayed; fetch it again |

## Verification
The assertions take for granted that cutThrough changes only while the buffer is empty. They also assume that retryReq and frameDone are never high in the same cycle as an accepted byte, and that in the default mode no frame is longer than the buffer. The bench changes the mode only after every frame has been released or discarded. It raises each control input only in its own cycle with rdReady low, and its frame lengths run from one byte up to the full depth and no further.

// File: rtl/tx_replay_pkg.sv
`timescale 1ns/1ps
package tx_replay_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;       // store the offered byte
    logic rdEn;       // advance the speculative read pointer
    logic rewind;     // speculative pointer back to committed pointer
    logic relFrame;   // committed pointer jumps to speculative pointer
    logic freeOnRead; // committed pointer follows each read
  } bufCtl_t;
endpackage

// File: rtl/tx_replay_dp.sv
`timescale 1ns/1ps
module tx_replay_dp
  import tx_replay_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufCtl_t           ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  output logic              wrFull,
  output logic              rdAvail,
  output logic [DATA_W-1:0] headData,
  output logic              headLast
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [DATA_W:0]  store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, cmPtr;
  logic [PTR_W-1:0] usedCnt;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) store[wrPtr[ADDR_W-1:0]] <= {wrLast, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cmPtr <= '0;
    end else begin
      if (ctl.wrEn) wrPtr <= wrPtr + 1'b1;
      if (ctl.rewind)      rdPtr <= cmPtr;
      else if (ctl.rdEn)   rdPtr <= rdPtr + 1'b1;
      if (ctl.relFrame)                     cmPtr <= rdPtr;
      else if (ctl.rdEn && ctl.freeOnRead)  cmPtr <= rdPtr + 1'b1;
    end
  end

  always_comb begin
    usedCnt  = wrPtr - cmPtr;
    wrFull   = (usedCnt == DEPTH_P);
    rdAvail  = (rdPtr != wrPtr);
    {headLast, headData} = store[rdPtr[ADDR_W-1:0]];
  end
endmodule

// File: rtl/tx_replay_ctl.sv
`timescale 1ns/1ps
module tx_replay_ctl
  import tx_replay_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cutThrough,
  input  logic    wrValid,
  input  logic    wrLast,
  input  logic    wrFull,
  input  logic    rdAvail,
  input  logic    headLast,
  input  logic    rdReady,
  input  logic    retryReq,
  input  logic    frameDone,
  output bufCtl_t ctl,
  output logic    rdValid,
  output logic    rdFrameAvail,
  output logic    restartReq
);
  localparam int CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0] frameCnt;
  logic awaitDone, bytesSent, dropping;
  logic beat, dropEn, retryHit, partialAbort, doneHit, cntInc, cntDec;

  always_comb begin
    rdValid      = !awaitDone && !dropping && rdAvail && (cutThrough || frameCnt != '0);
    beat         = rdValid && rdReady && !retryReq && !frameDone;
    dropEn       = dropping && rdAvail;
    retryHit     = retryReq && !dropping;
    partialAbort = retryHit && cutThrough && bytesSent;
    doneHit      = frameDone && awaitDone && !retryReq;
    cntInc       = ctl.wrEn && wrLast;
    cntDec       = doneHit || (dropEn && headLast) || (partialAbort && awaitDone);
    rdFrameAvail = (frameCnt != '0);

    ctl.wrEn       = wrValid && !wrFull;
    ctl.rdEn       = beat || dropEn;
    ctl.rewind     = retryHit && !cutThrough;
    ctl.relFrame   = doneHit;
    ctl.freeOnRead = cutThrough;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt   <= '0;
      awaitDone  <= 1'b0;
      bytesSent  <= 1'b0;
      dropping   <= 1'b0;
      restartReq <= 1'b0;
    end else begin
      if (cntInc && !cntDec)      frameCnt <= frameCnt + 1'b1;
      else if (cntDec && !cntInc) frameCnt <= frameCnt - 1'b1;

      if (doneHit || retryHit)     awaitDone <= 1'b0;
      else if (beat && headLast)   awaitDone <= 1'b1;

      if (doneHit || retryHit) bytesSent <= 1'b0;
      else if (beat)           bytesSent <= 1'b1;

      if (dropEn && headLast)                dropping <= 1'b0;
      else if (partialAbort && !awaitDone)   dropping <= 1'b1;

      restartReq <= partialAbort;
    end
  end
endmodule

// File: rtl/tx_replay_buf.sv
`timescale 1ns/1ps
module tx_replay_buf
  import tx_replay_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cutThrough,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  output logic              wrFull,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLast,
  input  logic              rdReady,
  output logic              rdFrameAvail,
  input  logic              retryReq,
  input  logic              frameDone,
  output logic              restartReq
);
  bufCtl_t ctl;
  logic    rdAvail;

  tx_replay_ctl #(.ADDR_W(ADDR_W)) uCtl (
    .clk(clk), .rstN(rstN), .cutThrough(cutThrough),
    .wrValid(wrValid), .wrLast(wrLast), .wrFull(wrFull),
    .rdAvail(rdAvail), .headLast(rdLast), .rdReady(rdReady),
    .retryReq(retryReq), .frameDone(frameDone), .ctl(ctl),
    .rdValid(rdValid), .rdFrameAvail(rdFrameAvail), .restartReq(restartReq)
  );

  tx_replay_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrData(wrData), .wrLast(wrLast), .wrFull(wrFull),
    .rdAvail(rdAvail), .headData(rdData), .headLast(rdLast)
  );
endmodule

// File: rtl/tx_replay_buf_chk.sv
`timescale 1ns/1ps
module tx_replay_buf_chk (
  input logic clk,
  input logic rstN,
  input logic cutThrough,
  input logic wrFull,
  input logic rdValid,
  input logic rdLast,
  input logic rdReady,
  input logic rdFrameAvail,
  input logic retryReq,
  input logic frameDone,
  input logic restartReq
);
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!cutThrough && wrFull && !frameDone) |=> wrFull); // R6

  AST_WAIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdReady && rdLast && !retryReq && !frameDone) |=> !rdValid); // R3

  AST_WHOLE_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!cutThrough && rdValid) |-> rdFrameAvail); // R2

  AST_RESTART_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |-> ($past(retryReq) && $past(cutThrough))); // R8

  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !restartReq); // R8

  AST_REPLAY_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (retryReq && !cutThrough) |=> !restartReq); // R4
endmodule

bind tx_replay_buf tx_replay_buf_chk uChk (
  .clk(clk), .rstN(rstN), .cutThrough(cutThrough), .wrFull(wrFull),
  .rdValid(rdValid), .rdLast(rdLast), .rdReady(rdReady),
  .rdFrameAvail(rdFrameAvail), .retryReq(retryReq),
  .frameDone(frameDone), .restartReq(restartReq)
);

// File: tb/tb_tx_replay_buf.sv
`timescale 1ns/1ps
module tb_tx_replay_buf;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cutThrough = 1'b0;
  logic wrValid = 1'b0, wrLast = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic rdReady = 1'b0, retryReq = 1'b0, frameDone = 1'b0;
  logic wrFull, rdValid, rdLast, rdFrameAvail, restartReq;
  logic [DATA_W-1:0] rdData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tx_replay_buf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .cutThrough(cutThrough),
    .wrValid(wrValid), .wrData(wrData), .wrLast(wrLast), .wrFull(wrFull),
    .rdValid(rdValid), .rdData(rdData), .rdLast(rdLast), .rdReady(rdReady),
    .rdFrameAvail(rdFrameAvail), .retryReq(retryReq),
    .frameDone(frameDone), .restartReq(restartReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic putByte(input logic [DATA_W-1:0] d, input logic last);
    @(negedge clk);
    wrValid = 1'b1; wrData = d; wrLast = last;
    @(negedge clk);
    wrValid = 1'b0; wrLast = 1'b0;
  endtask

  task automatic takeByte(input logic [DATA_W-1:0] d, input logic last, input string req);
    @(negedge clk);
    check(rdValid == 1'b1, {req, " valid"}, int'(rdValid), 1);
    check(rdData == d, {req, " data"}, int'(rdData), int'(d));
    check(rdLast == last, {req, " last"}, int'(rdLast), int'(last));
    rdReady = 1'b1;
    @(negedge clk);
    rdReady = 1'b0;
  endtask

  task automatic pulseRetry();
    @(negedge clk); retryReq = 1'b1;
    @(negedge clk); retryReq = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); frameDone = 1'b1;
    @(negedge clk); frameDone = 1'b0;
  endtask

  function automatic logic [DATA_W-1:0] pat(input int len, input int idx);
    return DATA_W'(len * 16 + idx);
  endfunction

  task automatic finish();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!rdValid && !rdFrameAvail && !wrFull && !restartReq, "R9 reset",
          int'({rdValid, rdFrameAvail, wrFull, restartReq}), 0);

    // R2: incomplete frame is not offered in the default mode
    putByte(8'hA0, 1'b0);
    putByte(8'hA1, 1'b0);
    @(negedge clk);
    check(!rdValid && !rdFrameAvail, "R2 incomplete", int'({rdValid, rdFrameAvail}), 0);
    putByte(8'hA2, 1'b1);
    check(rdValid && rdFrameAvail, "R2 complete", int'({rdValid, rdFrameAvail}), 3);
    // R5: frameDone before the end is read is ignored
    pulseDone();
    takeByte(8'hA0, 1'b0, "R5 early done");
    takeByte(8'hA1, 1'b0, "R5 early done");
    takeByte(8'hA2, 1'b1, "R5 early done");
    check(!rdValid, "R3 wait after last", int'(rdValid), 0);
    pulseDone();
    check(!rdFrameAvail && !rdValid, "R5 released", int'({rdFrameAvail, rdValid}), 0);

    // R4/R1/R6: sweep frame length and retry point
    for (int len = 1; len <= DEPTH; len++) begin
      for (int k = 0; k <= len; k++) begin
        for (int i = 0; i < len; i++) putByte(pat(len, i), (i == len - 1));
        if (len == DEPTH) begin
          check(wrFull, "R1 full at depth", int'(wrFull), 1);
          if (k == 0) begin
            putByte(8'hEE, 1'b1); // dropped: buffer full
          end
        end
        for (int i = 0; i < k; i++) takeByte(pat(len, i), (i == len - 1), "R3 first pass");
        if (len == DEPTH && k == len)
          check(wrFull, "R6 reading frees nothing", int'(wrFull), 1);
        pulseRetry();
        check(!restartReq, "R4 no restart", int'(restartReq), 0);
        for (int i = 0; i < len; i++) takeByte(pat(len, i), (i == len - 1), "R4 replay");
        check(!rdValid, "R3 wait after last", int'(rdValid), 0);
        pulseDone();
        check(!wrFull && !rdFrameAvail && !rdValid, "R5 space freed",
              int'({wrFull, rdFrameAvail, rdValid}), 0);
      end
    end

    // R3: two frames held, streamed in order
    putByte(8'h11, 1'b0); putByte(8'h12, 1'b1);
    putByte(8'h21, 1'b0); putByte(8'h22, 1'b0); putByte(8'h23, 1'b1);
    takeByte(8'h11, 1'b0, "R3 order"); takeByte(8'h12, 1'b1, "R3 order");
    pulseDone();
    check(rdFrameAvail, "R2 second frame held", int'(rdFrameAvail), 1);
    takeByte(8'h21, 1'b0, "R3 order"); takeByte(8'h22, 1'b0, "R3 order");
    takeByte(8'h23, 1'b1, "R3 order");
    pulseDone();
    check(!rdFrameAvail, "R2 all released", int'(rdFrameAvail), 0);

    // Low-latency mode, switched while empty
    @(negedge clk); cutThrough = 1'b1;
    for (int i = 0; i < DEPTH; i++) putByte(pat(9, i), 1'b0);
    check(wrFull && rdValid && !rdFrameAvail, "R7 stream before end",
          int'({wrFull, rdValid, rdFrameAvail}), 6);
    takeByte(pat(9, 0), 1'b0, "R7 stream");
    check(!wrFull, "R7 freed on read", int'(wrFull), 0);
    pulseRetry();
    check(restartReq, "R8 restart pulse", int'(restartReq), 1);
    @(negedge clk);
    check(!restartReq, "R8 single pulse", int'(restartReq), 0);
    repeat (DEPTH + 2) @(negedge clk);
    putByte(8'h5F, 1'b1); // tail of abandoned frame
    repeat (3) @(negedge clk);
    check(!rdValid && !rdFrameAvail && !wrFull, "R8 remainder discarded",
          int'({rdValid, rdFrameAvail, wrFull}), 0);
    // R8: retry before any byte read has no effect
    putByte(8'h71, 1'b0); putByte(8'h72, 1'b1);
    pulseRetry();
    check(!restartReq, "R8 early retry ignored", int'(restartReq), 0);
    takeByte(8'h71, 1'b0, "R8 early retry"); takeByte(8'h72, 1'b1, "R8 early retry");
    pulseDone();
    check(!rdFrameAvail && !rdValid, "R5 released low-latency",
          int'({rdFrameAvail, rdValid}), 0);

    finish();
  end
endmodule